// File: doc/BRIEF.md
# Pulse Width Capture Channel

This timer channel measures the width of a pulse on an input pin. The pin is synchronised to the clock. The channel latches a free-running time base value at the pulse's leading edge and again at its trailing edge. Software subtracts the two latched values to get the width in time base ticks.

The leading-edge value first goes into a staging register, B1. It moves into the readable register, B2, only in the cycle when the trailing edge is latched into register A. So A and B always read back as values from the same pulse. A polarity input chooses whether high pulses or low pulses are measured. A select input chooses which of two time base buses is sampled. A small register port lets software write A and B, read either one back, and clear the completion flag.

Top module: `pwc_channel`

## Requirements
- R1: The mode code 4'b0001 selects measurement. Every other code, including 4'b0000, acts as disabled. While disabled, no capture takes place and `flag_o` is held at 0.
- R2: `pin_lvl_o` shows `pin_i` delayed by a two-stage synchroniser: a change on `pin_i` appears after the second rising clock edge. This holds in every mode.
- R3: In measurement mode, a leading edge latches the selected time base into B1. It leaves `flag_o` unchanged and leaves the value read from B unchanged.
- R4: A trailing edge that follows a leading edge does three things in one clock cycle: it loads the selected time base into A, copies B1 into B2, and sets `flag_o`. A capture uses the time base value present at the third rising clock edge after `pin_i` changes.
- R5: After measurement mode is entered, trailing edges are ignored until a leading edge has been captured. After that, captures alternate between leading and trailing edges.
- R6: With `pol_i` = 0 the leading edge is rising and the trailing edge is falling, so high pulses are measured. With `pol_i` = 1 both edges are reversed, so low pulses are measured.
- R7: With `tb_sel_i` = 0, captures sample `tb0_i`. With `tb_sel_i` = 1, they sample `tb1_i`.
- R8: Further pulses while `flag_o` is already 1 overwrite A and B with the newest values, and `flag_o` stays 1.
- R9: A one-cycle pulse on `flag_clr_i` clears `flag_o`. If a trailing-edge capture happens in the same cycle, the flag is set instead.
- R10: Register writes use `wr_sel_i`: 0 writes A, and 1 writes both B1 and B2. A capture in the same cycle takes priority over the write. `rd_sel_i` = 0 reads A and `rd_sel_i` = 1 reads B2. After reset, A, B1, B2 and `flag_o` are all 0.
- R11: Leaving measurement mode resets the edge sequence. On return, the channel again waits for a leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb0_i | input | 16 | Time base bus 0 |
| tb1_i | input | 16 | Time base bus 1 |
| tb_sel_i | input | 1 | Time base select |
| mode_i | input | 4 | Channel mode code |
| pol_i | input | 1 | Pulse polarity |
| pin_i | input | 1 | Asynchronous input pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = A, 1 = B |
| wr_data_i | input | 16 | Write data |
| flag_clr_i | input | 1 | Flag clear strobe |
| rd_sel_i | input | 1 | Read source: 0 = A, 1 = B2 |
| rd_data_o | output | 16 | Read data |
| pin_lvl_o | output | 1 | Synchronised pin level |
| flag_o | output | 1 | Measurement complete flag |

## Verification
A vector table drives full pulses for all four combinations of polarity and bus select. Bus 1 carries the bit inverse of bus 0, so a wrong select shows up at once. The leading and trailing values differ, so a swapped register shows up as well. Directed cases then cover the following:
- A trailing edge arriving first after entry to the mode.
- A mode exit in the middle of a pulse.
- A second pulse while the flag is set.
- A clear that lands in the same cycle as a capture.
- A read of B between the two edges. This separates a double-buffered design from one that exposes B1 directly.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
   localparam int unsigned MODE_W = 4;
   localparam logic [MODE_W-1:0] MODE_OFF  = 4'b0000;
   localparam logic [MODE_W-1:0] MODE_MEAS = 4'b0001;

   typedef enum logic {
      SEQ_WAIT_LEAD  = 1'b0,
      SEQ_WAIT_TRAIL = 1'b1
   } seq_e;
endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] stg_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= 1'b0;
            else        stg_q[0] <= d_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= 1'b0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwc_edge_seq.sv
module pwc_edge_seq
   import pwc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic pol_i,
   input  logic meas_i,
   output logic lead_o,
   output logic trail_o
);
   logic prev_q;
   logic rise, fall, lead_edge, trail_edge;
   seq_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise       = lvl_i & ~prev_q;
   assign fall       = ~lvl_i & prev_q;
   assign lead_edge  = pol_i ? fall : rise;
   assign trail_edge = pol_i ? rise : fall;

   assign lead_o  = meas_i && (state_q == SEQ_WAIT_LEAD)  && lead_edge;
   assign trail_o = meas_i && (state_q == SEQ_WAIT_TRAIL) && trail_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state_q <= SEQ_WAIT_LEAD;
      else if (!meas_i) state_q <= SEQ_WAIT_LEAD;
      else if (lead_o)  state_q <= SEQ_WAIT_TRAIL;
      else if (trail_o) state_q <= SEQ_WAIT_LEAD;
   end
endmodule

// File: rtl/pwc_regs.sv
module pwc_regs #(
   parameter int unsigned TB_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TB_W-1:0] tb_i,
   input  logic            lead_i,
   input  logic            trail_i,
   input  logic            meas_i,
   input  logic            wr_en_i,
   input  logic            wr_sel_i,
   input  logic [TB_W-1:0] wr_data_i,
   input  logic            clr_i,
   output logic [TB_W-1:0] a_o,
   output logic [TB_W-1:0] b2_o,
   output logic            flag_o
);
   logic [TB_W-1:0] a_q, b1_q, b2_q;
   logic            flag_q;
   logic            wr_a, wr_b;

   assign wr_a = wr_en_i & ~wr_sel_i;
   assign wr_b = wr_en_i &  wr_sel_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q  <= '0;
         b1_q <= '0;
         b2_q <= '0;
      end else begin
         if (trail_i)   a_q <= tb_i;
         else if (wr_a) a_q <= wr_data_i;

         if (lead_i)    b1_q <= tb_i;
         else if (wr_b) b1_q <= wr_data_i;

         if (trail_i)   b2_q <= b1_q;
         else if (wr_b) b2_q <= wr_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (!meas_i) flag_q <= 1'b0;
      else if (trail_i) flag_q <= 1'b1;
      else if (clr_i)   flag_q <= 1'b0;
   end

   assign a_o    = a_q;
   assign b2_o   = b2_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/pwc_channel.sv
module pwc_channel
   import pwc_pkg::*;
#(
   parameter int unsigned TB_W        = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TB_W-1:0]   tb0_i,
   input  logic [TB_W-1:0]   tb1_i,
   input  logic              tb_sel_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              pol_i,
   input  logic              pin_i,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [TB_W-1:0]   wr_data_i,
   input  logic              flag_clr_i,
   input  logic              rd_sel_i,
   output logic [TB_W-1:0]   rd_data_o,
   output logic              pin_lvl_o,
   output logic              flag_o
);
   if (TB_W < 2) begin : g_bad_width
      $error("pwc_channel: TB_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwc_channel: SYNC_STAGES must be at least 2");
   end

   logic            meas;
   logic            lvl_s;
   logic            lead_s, trail_s;
   logic [TB_W-1:0] tb_s;
   logic [TB_W-1:0] a_q, b2_q;

   assign meas = (mode_i == MODE_MEAS);
   assign tb_s = tb_sel_i ? tb1_i : tb0_i;

   pwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (lvl_s)
   );

   pwc_edge_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (lvl_s),
      .pol_i   (pol_i),
      .meas_i  (meas),
      .lead_o  (lead_s),
      .trail_o (trail_s)
   );

   pwc_regs #(.TB_W(TB_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .tb_i      (tb_s),
      .lead_i    (lead_s),
      .trail_i   (trail_s),
      .meas_i    (meas),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .clr_i     (flag_clr_i),
      .a_o       (a_q),
      .b2_o      (b2_q),
      .flag_o    (flag_o)
   );

   assign rd_data_o = rd_sel_i ? b2_q : a_q;
   assign pin_lvl_o = lvl_s;
endmodule

// File: rtl/pwc_channel_chk.sv
module pwc_channel_chk
   import pwc_pkg::*;
#(
   parameter int unsigned TB_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pin_i,
   input logic [MODE_W-1:0] mode_i,
   input logic              flag_clr_i,
   input logic              wr_en_i,
   input logic              wr_sel_i,
   input logic              pin_lvl_o,
   input logic              flag_o,
   input logic              lead_s,
   input logic              trail_s,
   input logic [TB_W-1:0]   b2_q
);
   logic [1:0] up_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            up_cnt <= '0;
      else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
   end

   AST_OFF_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_i) != MODE_MEAS) |-> !flag_o); // R1

   AST_PIN_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt == 2'd3) |-> (pin_lvl_o == $past(pin_i, 2))); // R2

   AST_B2_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(b2_q) |-> ($past(trail_s) || $past(wr_en_i && wr_sel_i))); // R3

   AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> ($past(trail_s) && ($past(mode_i) == MODE_MEAS))); // R4

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_s && trail_s)); // R5

   AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> ($past(flag_clr_i) || ($past(mode_i) != MODE_MEAS))); // R9
endmodule

bind pwc_channel pwc_channel_chk #(.TB_W(TB_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pin_i      (pin_i),
   .mode_i     (mode_i),
   .flag_clr_i (flag_clr_i),
   .wr_en_i    (wr_en_i),
   .wr_sel_i   (wr_sel_i),
   .pin_lvl_o  (pin_lvl_o),
   .flag_o     (flag_o),
   .lead_s     (lead_s),
   .trail_s    (trail_s),
   .b2_q       (b2_q)
);

// File: tb/pwc_channel_tb.sv
module pwc_channel_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tb0_i = '0, tb1_i = '0;
   logic        tb_sel_i = 1'b0;
   logic [3:0]  mode_i = 4'b0000;
   logic        pol_i = 1'b0;
   logic        pin_i = 1'b0;
   logic        wr_en_i = 1'b0, wr_sel_i = 1'b0;
   logic [15:0] wr_data_i = '0;
   logic        flag_clr_i = 1'b0;
   logic        rd_sel_i = 1'b0;
   logic [15:0] rd_data_o;
   logic        pin_lvl_o, flag_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwc_channel dut_i (
      .clk(clk), .rst_n(rst_n), .tb0_i(tb0_i), .tb1_i(tb1_i), .tb_sel_i(tb_sel_i),
      .mode_i(mode_i), .pol_i(pol_i), .pin_i(pin_i), .wr_en_i(wr_en_i),
      .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .flag_clr_i(flag_clr_i),
      .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .pin_lvl_o(pin_lvl_o), .flag_o(flag_o)
   );

   typedef struct packed {
      logic        sel;
      logic        pol;
      logic [15:0] lead;
      logic [15:0] trail;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{1'b0, 1'b0, 16'h0010, 16'h0053},
      '{1'b1, 1'b0, 16'h1200, 16'h12F0},
      '{1'b0, 1'b1, 16'h7FF0, 16'h8004},
      '{1'b1, 1'b1, 16'hFFF8, 16'h0021}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic sel, output logic [15:0] v);
      rd_sel_i = sel;
      #1;
      v = rd_data_o;
   endtask

   task automatic set_tb(input logic [15:0] v);
      tb0_i = v;
      tb1_i = ~v;
   endtask

   task automatic wr(input logic sel, input logic [15:0] d);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
      cyc(1);
      wr_en_i = 1'b0;
   endtask

   task automatic enter(input logic pol, input logic sel);
      mode_i = 4'b0000; pol_i = pol; pin_i = pol; tb_sel_i = sel;
      cyc(4);
      mode_i = 4'b0001;
      cyc(1);
   endtask

   function automatic logic [15:0] seen(input logic sel, input logic [15:0] v);
      return sel ? ~v : v;
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R10 reset values
      rd(1'b0, v); chk("R10 reset A", v, 16'h0000);
      rd(1'b1, v); chk("R10 reset B", v, 16'h0000);
      chk("R10 reset flag", {15'd0, flag_o}, 16'd0);
      chk("R2 reset pin level", {15'd0, pin_lvl_o}, 16'd0);

      // R2 synchroniser latency
      pin_i = 1'b1;
      cyc(1); chk("R2 after one edge", {15'd0, pin_lvl_o}, 16'd0);
      cyc(1); chk("R2 after two edges", {15'd0, pin_lvl_o}, 16'd1);
      pin_i = 1'b0; cyc(3);

      // R1 disabled mode (0000 and 0101) does not capture
      set_tb(16'h1234);
      pin_i = 1'b1; cyc(4); pin_i = 1'b0; cyc(4);
      mode_i = 4'b0101;
      pin_i = 1'b1; cyc(4); pin_i = 1'b0; cyc(4);
      rd(1'b0, v); chk("R1 no capture A", v, 16'h0000);
      rd(1'b1, v); chk("R1 no capture B", v, 16'h0000);
      chk("R1 flag held low", {15'd0, flag_o}, 16'd0);
      mode_i = 4'b0000; cyc(1);

      // R10 writes
      wr(1'b0, 16'hAAAA);
      wr(1'b1, 16'h5555);
      rd(1'b0, v); chk("R10 write A", v, 16'hAAAA);
      rd(1'b1, v); chk("R10 write B", v, 16'h5555);

      // R6 R7 R4 vector table
      foreach (VECS[i]) begin
         enter(VECS[i].pol, VECS[i].sel);
         set_tb(VECS[i].lead);
         pin_i = ~VECS[i].pol; cyc(4);
         chk("R3 flag after lead", {15'd0, flag_o}, 16'd0);
         set_tb(VECS[i].trail);
         pin_i = VECS[i].pol; cyc(4);
         rd(1'b0, v); chk("R4 R6 R7 vector A", v, seen(VECS[i].sel, VECS[i].trail));
         rd(1'b1, v); chk("R4 R6 R7 vector B", v, seen(VECS[i].sel, VECS[i].lead));
         chk("R4 vector flag", {15'd0, flag_o}, 16'd1);
      end

      // R3 double buffer: B read stays old between edges
      enter(1'b0, 1'b0);
      wr(1'b1, 16'h5555);
      set_tb(16'h0100); pin_i = 1'b1; cyc(4);
      rd(1'b1, v); chk("R3 B unchanged after lead", v, 16'h5555);
      chk("R3 flag unchanged", {15'd0, flag_o}, 16'd0);
      set_tb(16'h0200); pin_i = 1'b0; cyc(4);
      rd(1'b1, v); chk("R4 B after trail", v, 16'h0100);
      rd(1'b0, v); chk("R4 A after trail", v, 16'h0200);

      // R8 overwrite while flag set
      set_tb(16'h0300); pin_i = 1'b1; cyc(4);
      set_tb(16'h0400); pin_i = 1'b0; cyc(4);
      rd(1'b0, v); chk("R8 A overwritten", v, 16'h0400);
      rd(1'b1, v); chk("R8 B overwritten", v, 16'h0300);
      chk("R8 flag stays", {15'd0, flag_o}, 16'd1);

      // R9 clear
      flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
      chk("R9 clear", {15'd0, flag_o}, 16'd0);
      // R9 set wins over simultaneous clear
      set_tb(16'h0500); pin_i = 1'b1; cyc(4);
      set_tb(16'h0600); pin_i = 1'b0;
      cyc(2); flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
      chk("R9 set wins", {15'd0, flag_o}, 16'd1);
      rd(1'b0, v); chk("R9 capture with clear", v, 16'h0600);

      // R5 interlock: trailing edge first is ignored
      mode_i = 4'b0000; pol_i = 1'b0; pin_i = 1'b1; cyc(4);
      mode_i = 4'b0001; cyc(1);
      set_tb(16'h0777); pin_i = 1'b0; cyc(4);
      rd(1'b0, v); chk("R5 early trail ignored", v, 16'h0600);
      chk("R5 flag not set", {15'd0, flag_o}, 16'd0);
      set_tb(16'h0800); pin_i = 1'b1; cyc(4);
      set_tb(16'h0900); pin_i = 1'b0; cyc(4);
      rd(1'b0, v); chk("R5 A after proper pulse", v, 16'h0900);
      rd(1'b1, v); chk("R5 B after proper pulse", v, 16'h0800);

      // R11 leaving the mode resets the sequence
      set_tb(16'h0A00); pin_i = 1'b1; cyc(4);
      mode_i = 4'b0000; cyc(2);
      chk("R1 flag cleared when disabled", {15'd0, flag_o}, 16'd0);
      mode_i = 4'b0001; cyc(1);
      set_tb(16'h0B00); pin_i = 1'b0; cyc(4);
      rd(1'b0, v); chk("R11 trail after re-entry ignored", v, 16'h0900);
      chk("R11 flag stays low", {15'd0, flag_o}, 16'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule